// File: doc/BRIEF.md
# Exposed-Pipeline Result Writeback Scheduler

This block schedules register writeback for a microcoded floating-point engine that has no interlocks. Every issued instruction word names two source registers, an opcode and a destination register. The block reads the two sources combinationally and hands them to the arithmetic units, which sit outside. The unit result returns through `unit_result` in the same cycle. The block parks that result in a circular result queue, at a slot that sits as many issues ahead as the opcode's fixed latency.

The destination field of an instruction does not name where that instruction's own result goes. It names the register that receives the queue slot draining in that cycle. The microcode compiler therefore places each destination on the instruction that issues exactly one latency after the producer. The block owns the register file, the result ring and the program counter. A vector-output instruction ends the program: it freezes the queue and the counter and raises a completion flag.

Top module: `lat_wb_sched`

## Requirements
- R1: The instruction word is decoded as source A = bits 24:18, source B = bits 17:11, opcode = bits 10:7, destination = bits 6:0. `opa_data` and `opb_data` show the registers named by A and B combinationally, whether or not `issue_valid` is high.
- R2: Opcode encoding and latency in issues: 0 no-op (no result); 1 add and 2 subtract, latency 5; 3 multiply, latency 7; 4 absolute value and 5 float-to-int, latency 2; 6 int-to-float, latency 3; 7 vector output; 8 sine and 9 cosine, latency 4; 10 to 15 simple operations, latency 2.
- R3: A result presented with issue number k and latency L is written into the register named by the destination field of issue k+L, at the clock edge of that issue. Issue numbering counts only instructions that advance the queue.
- R4: A destination of 0 discards the draining value. Register 0 always reads as zero.
- R5: A queue slot is emptied when it drains. A slot with nothing newly scheduled delivers zero the next time it comes round.
- R6: A no-op inserts nothing, but it still drains the head slot into its destination and advances the queue.
- R7: A latency-7 result occupies the slot that has just drained, and it is delivered 7 issues later.
- R8: A vector-output issue writes no register, does not advance the queue, leaves `pc` unchanged and drives `program_end` high in its issue cycle. `program_end` is low in every other cycle.
- R9: Every other valid issue increments `pc` by one, wrapping at 11 bits. A cycle with `issue_valid` low changes nothing.
- R10: Reset clears `pc`, every register and every queue slot.
- R11: When two results are scheduled for the same future issue, the one inserted later is the one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_word | input | 25 | Instruction word (source A, source B, opcode, destination) |
| unit_result | input | 32 | Result from the arithmetic unit for the issuing instruction |
| opa_data | output | 32 | Register named by source A |
| opb_data | output | 32 | Register named by source B |
| pc | output | 11 | Program counter |
| program_end | output | 1 | A vector-output instruction is issuing |

## Verification
The hardest state to reach from the ports is a collision in the ring: a long-latency result and a later short-latency result both aimed at the same future issue, possibly with a vector-output stall or idle cycles between them. Such a collision can only be produced by an exact issue schedule. The bench sets up one collision by hand and then runs a long seeded instruction stream that mixes every opcode, stalls and random destinations. An independent timeline model keyed by issue number predicts every register value. The registers are observed only through the two read ports, so every read-address field of the stream also serves as a probe.

// File: rtl/lat_wb_pkg.sv
package lat_wb_pkg;

   localparam int unsigned OPC_W   = 4;
   localparam int unsigned LAT_MAX = 7;
   localparam int unsigned LAT_W   = $clog2(LAT_MAX + 1);

   typedef enum logic [OPC_W-1:0] {
      OPC_IDLE  = 4'd0,
      OPC_ADD   = 4'd1,
      OPC_SUB   = 4'd2,
      OPC_MUL   = 4'd3,
      OPC_MAG   = 4'd4,
      OPC_TOINT = 4'd5,
      OPC_TOFLT = 4'd6,
      OPC_EMIT  = 4'd7,
      OPC_SINE  = 4'd8,
      OPC_COSN  = 4'd9,
      OPC_GT    = 4'd10,
      OPC_EQ    = 4'd11,
      OPC_MOVE  = 4'd12,
      OPC_PICK  = 4'd13,
      OPC_SGN   = 4'd14,
      OPC_RSQ   = 4'd15
   } wb_opc_e;

   function automatic logic [LAT_W-1:0] opc_latency(input logic [OPC_W-1:0] opc);
      case (wb_opc_e'(opc))
         OPC_IDLE, OPC_EMIT: opc_latency = LAT_W'(0);
         OPC_ADD, OPC_SUB:   opc_latency = LAT_W'(5);
         OPC_MUL:            opc_latency = LAT_W'(7);
         OPC_TOFLT:          opc_latency = LAT_W'(3);
         OPC_SINE, OPC_COSN: opc_latency = LAT_W'(4);
         default:            opc_latency = LAT_W'(2);
      endcase
   endfunction

endpackage

// File: rtl/wb_decode.sv
module wb_decode #(
   parameter int unsigned REG_AW = 7
) (
   input  logic [3*REG_AW+lat_wb_pkg::OPC_W-1:0] word,
   output logic [REG_AW-1:0]                     src_a,
   output logic [REG_AW-1:0]                     src_b,
   output logic [REG_AW-1:0]                     dst,
   output logic [lat_wb_pkg::LAT_W-1:0]          lat,
   output logic                                  has_result,
   output logic                                  is_emit
);
   import lat_wb_pkg::*;

   localparam int unsigned DST_LO = 0;
   localparam int unsigned OPC_LO = REG_AW;
   localparam int unsigned SRB_LO = REG_AW + OPC_W;
   localparam int unsigned SRA_LO = 2*REG_AW + OPC_W;

   logic [OPC_W-1:0] opc;

   always_comb begin
      dst        = word[DST_LO +: REG_AW];
      opc        = word[OPC_LO +: OPC_W];
      src_b      = word[SRB_LO +: REG_AW];
      src_a      = word[SRA_LO +: REG_AW];
      lat        = opc_latency(opc);
      is_emit    = (opc == OPC_EMIT);
      has_result = (opc != OPC_IDLE) && (opc != OPC_EMIT);
   end

endmodule

// File: rtl/wb_ring.sv
module wb_ring #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 7,
   parameter int unsigned LAT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              ins,
   input  logic [LAT_W-1:0]  ins_lat,
   input  logic [DATA_W-1:0] ins_data,
   output logic [DATA_W-1:0] head_data
);
   localparam int unsigned HPW   = $clog2(DEPTH);
   localparam int unsigned SUM_W = $clog2(DEPTH + (1 << LAT_W) + 1);

   logic [HPW-1:0]    head;
   logic [HPW-1:0]    tgt;
   logic [SUM_W-1:0]  sum;
   logic [DATA_W-1:0] slots [DEPTH];

   always_comb begin
      sum = SUM_W'(head) + SUM_W'(ins_lat);
      tgt = (sum >= SUM_W'(DEPTH)) ? HPW'(sum - SUM_W'(DEPTH)) : HPW'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     head <= '0;
      else if (adv)   head <= (head == HPW'(DEPTH-1)) ? '0 : head + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (adv && ins && tgt == HPW'(i))     q <= ins_data;
         else if (adv && head == HPW'(i))           q <= '0;
      end
      assign slots[i] = q;
   end

   assign head_data = slots[head];

   p_head_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      head < HPW'(DEPTH));
   p_ins_needs_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ins |-> adv);
   p_slot_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !(ins && tgt == head)) |=> slots[$past(head)] == '0);
   p_insert_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ins) |=> slots[$past(tgt)] == $past(ins_data));
   p_hold_no_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(head));

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned AW        = 7,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int unsigned NREG = 1 << AW;

   logic [DATA_W-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0 && ZERO_HARD) begin : g_const
         assign bank[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= '0;
            else if (we && waddr == AW'(i))   q <= wdata;
         end
         assign bank[i] = q;
      end
   end

   assign rdata_a = bank[raddr_a];
   assign rdata_b = bank[raddr_b];

   p_zero_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> waddr != '0);
   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> bank[$past(waddr)] == $past(wdata));
   p_reg0_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bank[0] == '0);

endmodule

// File: rtl/lat_wb_sched.sv
module lat_wb_sched #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REG_AW    = 7,
   parameter int unsigned PC_W      = 11,
   parameter int unsigned QDEPTH    = lat_wb_pkg::LAT_MAX,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  issue_valid,
   input  logic [3*REG_AW+lat_wb_pkg::OPC_W-1:0] issue_word,
   input  logic [DATA_W-1:0]                     unit_result,
   output logic [DATA_W-1:0]                     opa_data,
   output logic [DATA_W-1:0]                     opb_data,
   output logic [PC_W-1:0]                       pc,
   output logic                                  program_end
);
   import lat_wb_pkg::*;

   if (QDEPTH < LAT_MAX) begin : g_bad_depth
      $error("result ring shallower than the longest latency");
   end
   if (REG_AW < 1 || PC_W < 1) begin : g_bad_width
      $error("register address and counter widths must be positive");
   end

   logic [REG_AW-1:0] src_a, src_b, dst;
   logic [LAT_W-1:0]  lat;
   logic              has_result, is_emit;
   logic              step;
   logic [DATA_W-1:0] drain;

   wb_decode #(.REG_AW(REG_AW)) i_dec (
      .word       (issue_word),
      .src_a      (src_a),
      .src_b      (src_b),
      .dst        (dst),
      .lat        (lat),
      .has_result (has_result),
      .is_emit    (is_emit)
   );

   assign step        = issue_valid && !is_emit;
   assign program_end = issue_valid && is_emit;

   wb_ring #(.DATA_W(DATA_W), .DEPTH(QDEPTH), .LAT_W(LAT_W)) i_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (step),
      .ins       (step && has_result),
      .ins_lat   (lat),
      .ins_data  (unit_result),
      .head_data (drain)
   );

   wb_regfile #(.DATA_W(DATA_W), .AW(REG_AW), .ZERO_HARD(ZERO_HARD)) i_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (step && dst != '0),
      .waddr   (dst),
      .wdata   (drain),
      .raddr_a (src_a),
      .raddr_b (src_b),
      .rdata_a (opa_data),
      .rdata_b (opb_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= '0;
      else if (step) pc <= pc + 1'b1;
   end

   p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> pc == PC_W'($past(pc) + 1'b1));
   p_pc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(pc));
   p_emit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      program_end |=> $stable(pc));
   p_end_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> !program_end);

endmodule

// File: tb/test_lat_wb_sched.sv
module test_lat_wb_sched;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [24:0] issue_word = '0;
   logic [31:0] unit_result = '0;
   logic [31:0] opa_data, opb_data;
   logic [10:0] pc;
   logic        program_end;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic [31:0] exp_reg [128];
   logic [31:0] due [int];
   int          n_issue = 0;
   logic [10:0] exp_pc = '0;

   always #5 clk = ~clk;

   lat_wb_sched i_lat_wb_sched (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
      .unit_result(unit_result), .opa_data(opa_data), .opb_data(opb_data),
      .pc(pc), .program_end(program_end)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   function automatic int lat_of(input int op);
      case (op)
         0, 7:    return 0;
         1, 2:    return 5;
         3:       return 7;
         6:       return 3;
         8, 9:    return 4;
         default: return 2;
      endcase
   endfunction

   function automatic logic [24:0] mk(input int a, input int b, input int op, input int d);
      return {7'(a), 7'(b), 4'(op), 7'(d)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      foreach (exp_reg[i]) exp_reg[i] = '0;
      due.delete();
      n_issue = 0;
      exp_pc  = '0;
   endtask

   // one cycle: drive at negedge, check combinational outputs, clock, update model
   task automatic cyc1(input bit v, input logic [24:0] w, input logic [31:0] res);
      int a, b, op, d;
      logic [31:0] val;
      a  = int'(w[24:18]);
      b  = int'(w[17:11]);
      op = int'(w[10:7]);
      d  = int'(w[6:0]);
      issue_valid = v; issue_word = w; unit_result = res;
      #1;
      check(opa_data == exp_reg[a], "R1 port A", opa_data, exp_reg[a]);
      check(opb_data == exp_reg[b], "R1 port B", opb_data, exp_reg[b]);
      check(pc == exp_pc, "R9 pc", 32'(pc), 32'(exp_pc));
      check(program_end == (v && op == 7), "R8 end flag", 32'(program_end), 32'(v && op == 7));
      @(posedge clk);
      if (v && op != 7) begin
         val = due.exists(n_issue) ? due[n_issue] : 32'h0;
         if (due.exists(n_issue)) due.delete(n_issue);
         if (d != 0) exp_reg[d] = val;
         if (op != 0) due[n_issue + lat_of(op)] = res;
         n_issue++;
         exp_pc = exp_pc + 11'd1;
      end
      @(negedge clk);
   endtask

   task automatic peek(input int r, input logic [31:0] exp, input string tag);
      issue_valid = 1'b0; issue_word = mk(r, 0, 0, 0);
      #1;
      check(opa_data == exp, tag, opa_data, exp);
      @(posedge clk); @(negedge clk);
   endtask

   task automatic flush();
      for (int i = 0; i < 8; i++) cyc1(1'b1, mk(0, 0, 0, 0), 32'h0);
   endtask

   initial begin
      logic [31:0] v;
      logic [10:0] pc_hold;
      void'($urandom(32'h1d2c3b4a));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(pc == 11'd0, "R10 pc after reset", 32'(pc), 32'h0);
      // R10: every register clear after reset, read through both ports
      for (int r = 0; r < 128; r++) cyc1(1'b0, mk(r, 127 - r, 0, 0), 32'h0);

      // R2 R3 R6 R7: latency sweep over every opcode that advances the queue
      for (int op = 0; op < 16; op++) begin
         if (op == 7) continue;
         flush();
         v = 32'hC0DE_0000 | 32'(op);
         cyc1(1'b1, mk(op, op + 1, op, 0), v);
         for (int j = 1; j <= 7; j++) cyc1(1'b1, mk(0, 0, 0, 100 + j), 32'hDEAD_0000);
         for (int j = 1; j <= 7; j++)
            peek(100 + j, (op != 0 && j == lat_of(op)) ? v : 32'h0,
                 (op == 3) ? "R7 latency-7 slot" : (op == 0 ? "R6 no-op inserts nothing" : "R2 R3 latency"));
      end

      // R5: slot emptied on drain, second lap delivers zero
      flush();
      cyc1(1'b1, mk(0, 0, 12, 0), 32'h5555_AAAA);
      for (int j = 1; j <= 9; j++) cyc1(1'b1, mk(0, 0, 0, 30 + j), 32'h0);
      peek(32, 32'h5555_AAAA, "R5 first lap");
      peek(39, 32'h0, "R5 second lap empty");

      // R11: add (lat 5) at k and move (lat 2) at k+3 collide on issue k+5
      flush();
      cyc1(1'b1, mk(0, 0, 1, 0), 32'hAAAA_0001);
      cyc1(1'b1, mk(0, 0, 0, 0), 32'h0);
      cyc1(1'b1, mk(0, 0, 0, 0), 32'h0);
      cyc1(1'b1, mk(0, 0, 12, 0), 32'hBBBB_0002);
      cyc1(1'b1, mk(0, 0, 0, 20), 32'h0);
      cyc1(1'b1, mk(0, 0, 0, 21), 32'h0);
      peek(21, 32'hBBBB_0002, "R11 later insert wins");
      peek(20, 32'h0, "R11 neighbour empty");

      // R8: vector output stalls the queue and the counter; R4: destination 0 discards
      flush();
      cyc1(1'b1, mk(0, 0, 1, 0), 32'h1234_5678);
      pc_hold = pc;
      cyc1(1'b1, mk(0, 0, 7, 40), 32'h0);
      check(pc == pc_hold, "R8 pc held", 32'(pc), 32'(pc_hold));
      for (int j = 1; j <= 5; j++) cyc1(1'b1, mk(0, 0, 0, 40 + j), 32'h0);
      peek(40, 32'h0, "R8 no writeback");
      peek(45, 32'h1234_5678, "R8 queue did not advance");
      cyc1(1'b1, mk(0, 0, 4, 0), 32'hFFFF_0000);
      cyc1(1'b1, mk(0, 0, 0, 0), 32'h0);
      cyc1(1'b1, mk(0, 0, 0, 0), 32'h0);
      peek(0, 32'h0, "R4 register 0 stays zero");

      // R1 R3 R9 R11: seeded mixed stream against the timeline model
      for (int i = 0; i < 3000; i++) begin
         bit vv;
         vv = ($urandom % 5) != 0;
         cyc1(vv, mk($urandom % 128, $urandom % 128, $urandom % 16, $urandom % 128), $urandom);
      end
      for (int r = 0; r < 128; r++) cyc1(1'b0, mk(r, r, 0, 0), 32'h0);

      // R10: reset in the middle of pending results
      cyc1(1'b1, mk(0, 0, 3, 0), 32'h7777_0000);
      cyc1(1'b1, mk(0, 0, 12, 0), 32'h7777_0001);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      #1;
      check(pc == 11'd0, "R10 pc cleared", 32'(pc), 32'h0);
      for (int r = 0; r < 128; r++) cyc1(1'b0, mk(r, 127 - r, 0, 0), 32'h0);
      for (int j = 0; j < 8; j++) cyc1(1'b1, mk(0, 0, 0, 50 + j), 32'h0);
      for (int j = 0; j < 8; j++) peek(50 + j, 32'h0, "R10 queue empty");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule